// File: doc/BRIEF.md
# Sliding-Window Circular Stream Buffer

This block couples one producer and one consumer through a shared ring of 16-bit words. The producer hands over fixed groups of words, two by default, which land at consecutive addresses. The consumer sees a window of consecutive words, eight by default, starting at a read base. Each accepted read moves the base forward by a stride, one word by default, so successive windows overlap in all but one word. Both the write address and the window wrap at the top of the 1024-word storage.

Each side has its own valid/ready handshake. A start pulse on either side begins a new transfer. The producer marks its last group with an end flag. The consumer is told which window is the last full one, and the block discards the tail words that can never form a complete window. The storage is split into one bank per window position, so all window words are read in parallel with no multi-port memory.

Top module: `swin_ring_buf`

## Requirements
- R1: While reset is held and right after it is released, `wr_ready_o` is 1 and both `rd_valid_o` and `rd_end_o` are 0.
- R2: An accepted write group places word j, taken from bits [16j+15:16j] of `wr_data_i`, at address write_pointer+j. The write pointer then advances by the group size.
- R3: `wr_ready_o` is 0 whenever fewer than 2 locations are free. A location becomes free only when the read base has moved past it. While ready is 0, a group held on the input is not stored.
- R4: `rd_valid_o` is 1 exactly when at least 8 written, unretired words lie at and above the read base.
- R5: Window word k, carried on bits [16k+15:16k] of `rd_data_o`, is the word at address (base+k) mod 1024.
- R6: An accepted read (no end marker) advances the base by 1 and retires exactly one word.
- R7: After a group fills addresses 1022 and 1023, the next group goes to addresses 0 and 1.
- R8: A window whose base is above 1016 takes its remaining words from address 0 upward.
- R9: A pulse on `wr_start_i` or `rd_start_i` clears that side's pointer, the occupancy count and the end flag. Any handshake offered in the same cycle is ignored.
- R10: A group accepted with `wr_end_i` set holds `wr_ready_o` at 0. `rd_end_o` marks the window whose last word is the final written word. Accepting that window moves the base to the write pointer and empties the buffer, which makes `rd_valid_o` 0 and `wr_ready_o` 1.
- R11: While `rd_valid_o` is 1 and no read and no start occurs, `rd_valid_o` stays 1 and `rd_data_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Start of a producer transfer; clears the write pointer |
| wr_valid_i | input | 1 | Producer offers a group |
| wr_end_i | input | 1 | Offered group is the last of the transfer |
| wr_data_i | input | 32 | Group words, word 0 in the low bits |
| wr_ready_o | output | 1 | Block can take a group |
| rd_start_i | input | 1 | Start of a consumer transfer; clears the read base |
| rd_ready_i | input | 1 | Consumer takes the current window |
| rd_valid_o | output | 1 | A full window is available |
| rd_end_o | output | 1 | Current window is the last full one of the transfer |
| rd_data_o | output | 128 | Window words, word 0 (at the base) in the low bits |

## Verification
The bench fills the ring completely and then frees it one word at a time. A design that counts free space wrongly would either overwrite unread words, which shows up as corrupted windows, or stall with space available. A long throttled run sends both pointers through the top address several times. A broken write wrap or a window that fails to wrap returns wrong words at the seam. The bench checks the valid threshold at exactly six and eight stored words, and it checks that a start pulse discards both the stored data and any write offered alongside it. Its end-of-transfer case checks that exactly the thirteenth window of a twenty-word transfer is flagged, and that the buffer is empty and writable afterwards.

// File: rtl/swin_pkg.sv
package swin_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_DEPTH  = 1024;
  localparam int unsigned DEF_GROUP  = 2;
  localparam int unsigned DEF_WIN    = 8;
  localparam int unsigned DEF_STRIDE = 1;
endpackage

// File: rtl/swin_bank.sv
module swin_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ROWS   = 128,
  localparam int unsigned RW    = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [RW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [RW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/swin_rotate.sv
module swin_rotate #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN    = 8,
  localparam int unsigned BW    = $clog2(WIN)
) (
  input  logic [WIN*DATA_W-1:0] bank_i,
  input  logic [BW-1:0]         shift_i,
  output logic [WIN*DATA_W-1:0] win_o
);
  // window slot k lives in bank (shift + k) mod WIN
  for (genvar k = 0; k < WIN; k++) begin : g_slot
    logic [BW-1:0] sel;
    assign sel = BW'(shift_i + BW'(k));
    assign win_o[k*DATA_W +: DATA_W] = bank_i[sel*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/swin_ctrl.sv
module swin_ctrl #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned GROUP  = 2,
  parameter int unsigned WIN    = 8,
  parameter int unsigned STRIDE = 1,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_start_i,
  input  logic          wr_valid_i,
  input  logic          wr_end_i,
  output logic          wr_ready_o,
  output logic          wr_fire_o,
  output logic [AW-1:0] wr_ptr_o,
  input  logic          rd_start_i,
  input  logic          rd_ready_i,
  output logic          rd_valid_o,
  output logic          rd_end_o,
  output logic [AW-1:0] rd_ptr_o
);
  logic [CW-1:0] count_q, count_d, free;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          closed_q, any_start, rd_fire;

  assign any_start  = wr_start_i | rd_start_i;
  assign free       = CW'(DEPTH) - count_q;
  assign wr_ready_o = !closed_q && (free >= CW'(GROUP));
  assign rd_valid_o = count_q >= CW'(WIN);
  assign rd_end_o   = rd_valid_o && closed_q && (count_q == CW'(WIN));
  assign wr_fire_o  = wr_valid_i && wr_ready_o && !any_start;
  assign rd_fire    = rd_ready_i && rd_valid_o && !any_start;
  assign wr_ptr_o   = wr_ptr_q;
  assign rd_ptr_o   = rd_ptr_q;

  always_comb begin
    count_d = count_q;
    if (wr_fire_o) count_d = count_d + CW'(GROUP);
    if (rd_fire)   count_d = count_d - CW'(STRIDE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      closed_q <= 1'b0;
    end else if (any_start) begin
      count_q  <= '0;
      closed_q <= 1'b0;
      if (wr_start_i) wr_ptr_q <= '0;
      if (rd_start_i) rd_ptr_q <= '0;
    end else begin
      if (wr_fire_o) wr_ptr_q <= wr_ptr_q + AW'(GROUP);
      if (rd_fire && rd_end_o) begin
        // drop the tail that can never fill a window
        count_q  <= '0;
        closed_q <= 1'b0;
        rd_ptr_q <= wr_ptr_q;
      end else begin
        count_q <= count_d;
        if (rd_fire) rd_ptr_q <= rd_ptr_q + AW'(STRIDE);
        if (wr_fire_o && wr_end_i) closed_q <= 1'b1;
      end
    end
  end

  p_write_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire_o |=> wr_ptr_q == $past(wr_ptr_q) + AW'(GROUP));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  p_read_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && !rd_end_o) |=> rd_ptr_q == $past(rd_ptr_q) + AW'(STRIDE));
  p_start_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |=> (wr_ptr_q == '0) && (count_q == '0) && !rd_valid_o);
  p_end_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && rd_end_o) |=> (rd_ptr_q == $past(wr_ptr_q)) && !rd_valid_o && wr_ready_o);
  p_hold_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i && !any_start) |=> rd_valid_o);
endmodule

// File: rtl/swin_ring_buf.sv
module swin_ring_buf #(
  parameter int unsigned DATA_W = swin_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = swin_pkg::DEF_DEPTH,
  parameter int unsigned GROUP  = swin_pkg::DEF_GROUP,
  parameter int unsigned WIN    = swin_pkg::DEF_WIN,
  parameter int unsigned STRIDE = swin_pkg::DEF_STRIDE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_start_i,
  input  logic                    wr_valid_i,
  input  logic                    wr_end_i,
  input  logic [GROUP*DATA_W-1:0] wr_data_i,
  output logic                    wr_ready_o,
  input  logic                    rd_start_i,
  input  logic                    rd_ready_i,
  output logic                    rd_valid_o,
  output logic                    rd_end_o,
  output logic [WIN*DATA_W-1:0]   rd_data_o
);
  // DEPTH and WIN are powers of two, GROUP <= WIN, STRIDE <= WIN
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned BW   = $clog2(WIN);
  localparam int unsigned ROWS = DEPTH / WIN;
  localparam int unsigned RW   = AW - BW;

  logic [AW-1:0]         wr_ptr, rd_ptr;
  logic                  wr_fire;
  logic [WIN*DATA_W-1:0] bank_rd;

  swin_ctrl #(
    .DEPTH(DEPTH), .GROUP(GROUP), .WIN(WIN), .STRIDE(STRIDE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_start_i (wr_start_i),
    .wr_valid_i (wr_valid_i),
    .wr_end_i   (wr_end_i),
    .wr_ready_o (wr_ready_o),
    .wr_fire_o  (wr_fire),
    .wr_ptr_o   (wr_ptr),
    .rd_start_i (rd_start_i),
    .rd_ready_i (rd_ready_i),
    .rd_valid_o (rd_valid_o),
    .rd_end_o   (rd_end_o),
    .rd_ptr_o   (rd_ptr)
  );

  // bank b holds addresses with addr mod WIN == b, so any window hits each bank once
  for (genvar b = 0; b < WIN; b++) begin : g_bank
    logic              we;
    logic [RW-1:0]     wrow, rrow;
    logic [DATA_W-1:0] wd;
    logic [AW-1:0]     ra;

    always_comb begin
      logic [AW-1:0] wa;
      we   = 1'b0;
      wrow = '0;
      wd   = '0;
      for (int j = 0; j < GROUP; j++) begin
        wa = wr_ptr + AW'(j);
        if (wa[BW-1:0] == BW'(b)) begin
          we   = wr_fire;
          wrow = wa[AW-1:BW];
          wd   = wr_data_i[j*DATA_W +: DATA_W];
        end
      end
    end

    assign ra   = rd_ptr + AW'(BW'(BW'(b) - rd_ptr[BW-1:0]));
    assign rrow = ra[AW-1:BW];

    swin_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank (
      .clk_i   (clk_i),
      .we_i    (we),
      .waddr_i (wrow),
      .wdata_i (wd),
      .raddr_i (rrow),
      .rdata_o (bank_rd[b*DATA_W +: DATA_W])
    );
  end

  swin_rotate #(.DATA_W(DATA_W), .WIN(WIN)) u_rot (
    .bank_i  (bank_rd),
    .shift_i (rd_ptr[BW-1:0]),
    .win_o   (rd_data_o)
  );

  p_window_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i && !wr_start_i && !rd_start_i) |=> $stable(rd_data_o));
  p_end_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_end_o |-> rd_valid_o && !wr_ready_o);
endmodule

// File: tb/sim_swin_ring_buf.sv
module sim_swin_ring_buf;
  localparam int W = 16;
  localparam int DEPTH = 1024;
  localparam int WIN = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_start_i = 1'b0, wr_valid_i = 1'b0, wr_end_i = 1'b0;
  logic [2*W-1:0]  wr_data_i = '0;
  logic            wr_ready_o;
  logic            rd_start_i = 1'b0, rd_ready_i;
  logic            rd_valid_o, rd_end_o;
  logic [WIN*W-1:0] rd_data_o;

  swin_ring_buf u0 (.*);

  always #10 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] exp_q[$];
  bit  end_seen = 1'b0;
  int  rd_budget = 0;
  bit  rd_throttle = 1'b0;
  int  rd_addr = 0, wr_addr = 0;
  int  wseq = 1;
  int  cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] win_word(int k);
    return rd_data_o[k*W +: W];
  endfunction

  // driver: one group, scoreboard push on acceptance; call and return at posedge+1
  task automatic wr_group(input bit endf);
    logic [W-1:0] w0, w1;
    w0 = W'(wseq); w1 = W'(wseq + 1); wseq += 2;
    wr_valid_i = 1'b1; wr_end_i = endf; wr_data_i = {w1, w0};
    do @(negedge clk_i); while (!wr_ready_o);
    exp_q.push_back(w0); exp_q.push_back(w1);
    wr_addr = (wr_addr + 2) % DEPTH;
    if (endf) end_seen = 1'b1;
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0; wr_end_i = 1'b0;
  endtask

  task automatic start_pulse(input bit w, input bit r);
    wr_start_i = w; rd_start_i = r;
    @(posedge clk_i); #1;
    wr_start_i = 1'b0; rd_start_i = 1'b0;
    if (w) wr_addr = 0;
    if (r) rd_addr = 0;
    end_seen = 1'b0;
  endtask

  task automatic start_both();
    start_pulse(1'b1, 1'b1);
    exp_q.delete();
  endtask

  task automatic rd_n(input int n);
    rd_budget = n;
    wait (rd_budget == 0);
    @(posedge clk_i); #1;
  endtask

  // read-ready driver
  initial begin
    rd_ready_i = 1'b0;
    forever begin
      @(posedge clk_i); #1;
      rd_ready_i = (rd_budget > 0) && (!rd_throttle || (cyc % 3 != 0));
      cyc++;
    end
  end

  // monitor: compare every accepted window against the scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && rd_valid_o && rd_ready_i && !wr_start_i && !rd_start_i) begin
        string tag;
        bit ok, exp_end;
        tag = (rd_addr > DEPTH - WIN) ? "R8 R7 window" : "R2 R5 R6 window";
        if (exp_q.size() < WIN) begin
          chk(1'b0, "R4", "valid with short data", exp_q.size(), WIN);
        end else begin
          ok = 1'b1;
          for (int k = 0; k < WIN; k++) if (win_word(k) !== exp_q[k]) ok = 1'b0;
          chk(ok, tag, "word0", win_word(0), exp_q[0]);
          exp_end = end_seen && (exp_q.size() == WIN);
          chk(rd_end_o == exp_end, "R10", "rd_end_o", rd_end_o, exp_end);
          if (exp_end) begin
            exp_q.delete(); end_seen = 1'b0; rd_addr = wr_addr;
          end else begin
            void'(exp_q.pop_front()); rd_addr = (rd_addr + 1) % DEPTH;
          end
        end
        if (rd_budget > 0) rd_budget--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(wr_ready_o == 1'b1, "R1", "wr_ready_o in reset", wr_ready_o, 1);
    chk(rd_valid_o == 1'b0, "R1", "rd_valid_o in reset", rd_valid_o, 0);
    @(posedge clk_i); #1; rst_ni = 1'b1;
    @(negedge clk_i);
    chk(wr_ready_o == 1'b1, "R1", "wr_ready_o after reset", wr_ready_o, 1);
    chk(rd_valid_o == 1'b0 && rd_end_o == 1'b0, "R1", "rd flags after reset",
        {rd_valid_o, rd_end_o}, 0);
    @(posedge clk_i); #1;

    // threshold and hold
    start_both();
    repeat (3) wr_group(1'b0);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b0, "R4", "valid at 6 words", rd_valid_o, 0);
    @(posedge clk_i); #1;
    wr_group(1'b0);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b1, "R4", "valid at 8 words", rd_valid_o, 1);
    chk(win_word(0) == exp_q[0] && win_word(7) == exp_q[7], "R5", "window 0..7",
        win_word(7), exp_q[7]);
    repeat (3) @(negedge clk_i);
    chk(rd_valid_o == 1'b1 && win_word(0) == exp_q[0], "R11", "hold without ready",
        win_word(0), exp_q[0]);
    @(posedge clk_i); #1;

    // fill completely, then free one word at a time
    repeat (508) wr_group(1'b0);
    @(negedge clk_i);
    chk(wr_ready_o == 1'b0, "R3", "ready when full", wr_ready_o, 0);
    @(posedge clk_i); #1;
    wr_valid_i = 1'b1; wr_data_i = {16'hDEAD, 16'hDEAD};
    repeat (3) @(posedge clk_i);
    #1 wr_valid_i = 1'b0;
    rd_n(1);
    @(negedge clk_i);
    chk(wr_ready_o == 1'b0, "R3", "ready with one free", wr_ready_o, 0);
    @(posedge clk_i); #1;
    rd_n(1);
    @(negedge clk_i);
    chk(wr_ready_o == 1'b1, "R3", "ready with two free", wr_ready_o, 1);
    @(posedge clk_i); #1;

    // long throttled run, both pointers wrap several times
    rd_throttle = 1'b1;
    fork
      begin
        for (int i = 0; i < 1500; i++) begin
          wr_group(1'b0);
          if (i % 7 == 6) begin @(posedge clk_i); #1; end
        end
      end
      begin
        rd_n(1022 + 3000 - 7);
      end
    join
    rd_throttle = 1'b0;
    @(negedge clk_i);
    chk(rd_valid_o == 1'b0, "R4", "valid with 7 left", rd_valid_o, 0);
    chk(exp_q.size() == 7, "R6", "words left after run", exp_q.size(), 7);
    @(posedge clk_i); #1;

    // start pulses
    start_both();
    repeat (4) wr_group(1'b0);
    start_pulse(1'b0, 1'b1);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b0, "R9", "valid after read start", rd_valid_o, 0);
    @(posedge clk_i); #1;
    repeat (4) wr_group(1'b0);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b1 && win_word(0) == exp_q[0] && win_word(7) == exp_q[7],
        "R9", "base back at 0", win_word(0), exp_q[0]);
    @(posedge clk_i); #1;
    wr_valid_i = 1'b1; wr_data_i = {16'hBEEF, 16'hBEEF};
    start_pulse(1'b1, 1'b0);
    wr_valid_i = 1'b0;
    @(negedge clk_i);
    chk(rd_valid_o == 1'b0, "R9", "valid after write start", rd_valid_o, 0);
    @(posedge clk_i); #1;
    repeat (3) wr_group(1'b0);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b0, "R9", "group with start ignored", rd_valid_o, 0);
    @(posedge clk_i); #1;
    wr_group(1'b0);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b1 && win_word(0) == exp_q[exp_q.size()-8]
        && win_word(7) == exp_q[exp_q.size()-1], "R9", "write pointer back at 0",
        win_word(0), exp_q[exp_q.size()-8]);
    @(posedge clk_i); #1;

    // end of transfer
    start_both();
    repeat (9) wr_group(1'b0);
    wr_group(1'b1);
    @(negedge clk_i);
    chk(wr_ready_o == 1'b0, "R10", "ready after end group", wr_ready_o, 0);
    chk(rd_end_o == 1'b0, "R10", "end flag with 20 words", rd_end_o, 0);
    @(posedge clk_i); #1;
    rd_n(13);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b0 && rd_end_o == 1'b0, "R10", "empty after last window",
        {rd_valid_o, rd_end_o}, 0);
    chk(wr_ready_o == 1'b1, "R10", "ready after flush", wr_ready_o, 1);
    @(posedge clk_i); #1;
    repeat (4) wr_group(1'b0);
    @(negedge clk_i);
    chk(rd_valid_o == 1'b1 && win_word(0) == exp_q[0], "R10", "base at write pointer",
        win_word(0), exp_q[0]);
    @(posedge clk_i); #1;
    rd_n(1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule